// File: doc/BRIEF.md
# Charge Pump Supply Power Sequencer

This block orders the bring-up and take-down of a dual-rail charge pump supply. It runs on the slow internal timing clock, and every interval is a parameter counted in ticks of that clock. When enable is accepted, the block turns on the reference first. After that it turns on the tripler boost stage, the doubler-to-sextupler stage, the inverting stage and the positive regulator, each a fixed number of ticks after the one before. While the positive regulator is not yet on, a forced-clock flag tells the clock mux to stay on the internal pump clock. Once the positive rail comparator reports the rail is up, and a further interval has passed, the negative regulator starts and a one-tick done strobe is issued.

When enable drops, the block switches off the negative regulator at once. The positive regulator stays on for a hold interval and then goes off. After a drain interval the pump stages and the reference go off. The busy flag is high for the whole stop sequence. An overcurrent flag on either rail is ignored for a masking window after startup begins. After that window, an overcurrent flag turns every stage off at once and latches a fault. Only enable going low and then high again clears the fault. After power-on reset the block does not start until it has seen enable low. All inputs are synchronous to the clock.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is asserted, every stage enable, forcedClk, startDone, busy and fault are low.
- R2: Startup timing. refOn rises on the first clock edge that samples enable high while the block is idle and armed. boost3On rises T_B3 edges after that, boost6On T_B6 edges after boost3On, negPumpOn T_NP edges after boost6On, and posRegOn T_PR edges after negPumpOn.
- R3: forcedClk rises together with refOn and falls on the same edge on which posRegOn rises.
- R4: With posRegOn high, negRegOn rises T_NR edges after the first edge that samples posRailUp high. startDone is high for exactly that one cycle.
- R5: Stage enables are ordered ref, boost3, boost6, negPump, posReg, negReg. A stage is never on unless every earlier stage is on.
- R6: Enable low with posRegOn high starts the stop sequence. On the next edge negRegOn falls and busy rises. posRegOn falls T_HOLD edges later. T_DRAIN edges after that, all remaining stages fall and busy falls.
- R7: Enable low before posRegOn has risen skips the remaining startup steps and the hold interval. Busy rises on the next edge, and all stages and busy fall T_DRAIN edges later.
- R8: Enable high during the stop sequence does not shorten it. refOn rises again on the edge after the stop sequence ends.
- R9: If enable is already high when reset is released, no stage turns on until enable has been sampled low at least once.
- R10: During startup and run, ovcPos and ovcNeg are ignored on the first T_MASK edges after refOn rises.
- R11: After the mask window, an overcurrent flag seen during startup or run clears all stages and sets fault on the next edge. Fault stays set while enable is low. The first edge that samples enable high afterwards clears fault and starts a new startup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timing clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| enable | input | 1 | Supply enable, active high |
| posRailUp | input | 1 | Positive rail comparator, high when the rail is up |
| ovcPos | input | 1 | Overcurrent flag of the positive rail |
| ovcNeg | input | 1 | Overcurrent flag of the negative rail |
| refOn | output | 1 | Reference enable |
| boost3On | output | 1 | Tripler boost stage enable |
| boost6On | output | 1 | Sextupler boost stage enable |
| negPumpOn | output | 1 | Inverting pump stage enable |
| posRegOn | output | 1 | Positive regulator enable |
| negRegOn | output | 1 | Negative regulator enable |
| forcedClk | output | 1 | Holds the pump clock on the internal source |
| startDone | output | 1 | One-cycle strobe when startup completes |
| busy | output | 1 | Stop sequence in progress |
| fault | output | 1 | Short-circuit latch-off active |

## Verification
A corrupted interval counter shows up as a stage edge that is early or late by some number of edges. The bench counts every interval edge by edge, so such an error is caught at the first transition it moves. A wrong state decode shows up as soon as the next stage should change: a missed hold phase in the stop sequence, a skipped restart, or stages left on after a fault. If the mask counter or the arming flag is wrong, the block latches off or starts one edge too early. The bench drives these boundaries at the exact edge where the behaviour must change.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  localparam int NSTAGE  = 6;
  localparam int STG_REF = 0;
  localparam int STG_B3  = 1;
  localparam int STG_B6  = 2;
  localparam int STG_NP  = 3;
  localparam int STG_PR  = 4;
  localparam int STG_NR  = 5;

  typedef enum logic [2:0] {
    IV_B3, IV_B6, IV_NP, IV_PR, IV_NR, IV_HOLD, IV_DRAIN
  } ivalSel_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WB3, ST_WB6, ST_WNP, ST_WPR, ST_WRAIL, ST_WNR, ST_RUN,
    ST_HOLD, ST_DRAIN, ST_FLT, ST_FLTLOW
  } seqState_e;

  typedef struct packed {
    logic [NSTAGE-1:0] stageSet;
    logic [NSTAGE-1:0] stageClr;
    logic              load;
    ivalSel_e          sel;
    logic              maskClr;
  } seqStrobe_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rail_seq_path.sv
module rail_seq_path
  import rail_seq_pkg::*;
#(
  parameter int T_B3    = 5500,
  parameter int T_B6    = 2000,
  parameter int T_NP    = 2000,
  parameter int T_PR    = 3300,
  parameter int T_NR    = 6100,
  parameter int T_HOLD  = 5000,
  parameter int T_DRAIN = 2000,
  parameter int T_MASK  = 18000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  output logic [NSTAGE-1:0] stageQ,
  output logic              forcedClk,
  output logic              startDone,
  output logic              cntDone,
  output logic              maskDone
);

  localparam int MAXA   = maxInt(maxInt(T_B3, T_B6), maxInt(T_NP, T_PR));
  localparam int MAXB   = maxInt(maxInt(T_NR, T_HOLD), T_DRAIN);
  localparam int MAXI   = maxInt(MAXA, MAXB);
  localparam int CNT_W  = $clog2(MAXI + 1);
  localparam int MASK_W = $clog2(T_MASK + 1);
  localparam logic [MASK_W-1:0] MASK_END = MASK_W'(T_MASK);

  logic [CNT_W-1:0]  ivalLen;
  logic [CNT_W-1:0]  cnt;
  logic [MASK_W-1:0] maskCnt;

  // interval length selected by the control
  always_comb begin
    case (stb.sel)
      IV_B3:   ivalLen = CNT_W'(T_B3);
      IV_B6:   ivalLen = CNT_W'(T_B6);
      IV_NP:   ivalLen = CNT_W'(T_NP);
      IV_PR:   ivalLen = CNT_W'(T_PR);
      IV_NR:   ivalLen = CNT_W'(T_NR);
      IV_HOLD: ivalLen = CNT_W'(T_HOLD);
      default: ivalLen = CNT_W'(T_DRAIN);
    endcase
  end

  // down counter: loaded with N-1 so the next event lands N edges later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (stb.load)         cnt <= ivalLen - CNT_W'(1);
    else if (cnt != '0)        cnt <= cnt - CNT_W'(1);
  end
  assign cntDone = (cnt == '0);

  // short-circuit mask window, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   maskCnt <= '0;
    else if (stb.maskClr)        maskCnt <= '0;
    else if (maskCnt != MASK_END) maskCnt <= maskCnt + MASK_W'(1);
  end
  assign maskDone = (maskCnt == MASK_END);

  // one enable flop per stage
  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 stageQ[g] <= 1'b0;
      else if (stb.stageClr[g])  stageQ[g] <= 1'b0;
      else if (stb.stageSet[g])  stageQ[g] <= 1'b1;
    end
    if (g > 0) begin : g_ord
      a_r5_stage_order: assert property (@(posedge clk) disable iff (!rstN)
        stageQ[g] |-> stageQ[g-1]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      forcedClk <= 1'b0;
      startDone <= 1'b0;
    end else begin
      startDone <= stb.stageSet[STG_NR];
      if (stb.stageSet[STG_PR] || stb.stageClr[STG_REF]) forcedClk <= 1'b0;
      else if (stb.stageSet[STG_REF])                    forcedClk <= 1'b1;
    end
  end

  a_r3_forced_ends: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stageQ[STG_PR]) |-> !forcedClk);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    startDone |=> !startDone);

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       posRailUp,
  input  logic       ovcPos,
  input  logic       ovcNeg,
  input  logic       cntDone,
  input  logic       maskDone,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       fault
);

  seqState_e st, nxt;
  logic      armed;
  logic      runState;
  logic      prOnState;
  logic      shortHit;

  assign runState  = st inside {ST_WB3, ST_WB6, ST_WNP, ST_WPR, ST_WRAIL, ST_WNR, ST_RUN};
  assign prOnState = st inside {ST_WRAIL, ST_WNR, ST_RUN};
  assign shortHit  = runState && maskDone && (ovcPos || ovcNeg);
  assign busy      = st inside {ST_HOLD, ST_DRAIN};
  assign fault     = st inside {ST_FLT, ST_FLTLOW};

  // armed once enable has been seen low after power-on reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        armed <= 1'b0;
    else if (!enable) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt = st;
    stb = '0;
    stb.sel = IV_DRAIN;
    case (st)
      ST_IDLE, ST_FLTLOW: begin
        if (enable && (armed || st == ST_FLTLOW)) begin
          stb.stageSet[STG_REF] = 1'b1;
          stb.load    = 1'b1;
          stb.sel     = IV_B3;
          stb.maskClr = 1'b1;
          nxt = ST_WB3;
        end
      end
      ST_FLT: if (!enable) nxt = ST_FLTLOW;
      ST_HOLD: begin
        if (cntDone) begin
          stb.stageClr[STG_PR] = 1'b1;
          stb.load = 1'b1;
          stb.sel  = IV_DRAIN;
          nxt = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (cntDone) begin
          stb.stageClr = '1;
          nxt = ST_IDLE;
        end
      end
      default: begin
        if (shortHit) begin
          stb.stageClr = '1;
          nxt = ST_FLT;
        end else if (!enable) begin
          stb.stageClr[STG_NR] = 1'b1;
          stb.load = 1'b1;
          if (prOnState) begin
            stb.sel = IV_HOLD;
            nxt = ST_HOLD;
          end else begin
            stb.sel = IV_DRAIN;
            nxt = ST_DRAIN;
          end
        end else begin
          case (st)
            ST_WB3: if (cntDone) begin
              stb.stageSet[STG_B3] = 1'b1;
              stb.load = 1'b1; stb.sel = IV_B6; nxt = ST_WB6;
            end
            ST_WB6: if (cntDone) begin
              stb.stageSet[STG_B6] = 1'b1;
              stb.load = 1'b1; stb.sel = IV_NP; nxt = ST_WNP;
            end
            ST_WNP: if (cntDone) begin
              stb.stageSet[STG_NP] = 1'b1;
              stb.load = 1'b1; stb.sel = IV_PR; nxt = ST_WPR;
            end
            ST_WPR: if (cntDone) begin
              stb.stageSet[STG_PR] = 1'b1;
              nxt = ST_WRAIL;
            end
            ST_WRAIL: if (posRailUp) begin
              stb.load = 1'b1; stb.sel = IV_NR; nxt = ST_WNR;
            end
            ST_WNR: if (cntDone) begin
              stb.stageSet[STG_NR] = 1'b1;
              nxt = ST_RUN;
            end
            default: ;
          endcase
        end
      end
    endcase
  end

  a_r9_wait_armed: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && !armed) |=> (st == ST_IDLE));
  a_r10_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (runState && !maskDone) |=> !fault);
  a_r11_fault_holds: assert property (@(posedge clk) disable iff (!rstN)
    (fault && !enable) |=> fault);

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rail_seq_pkg::*;
#(
  parameter int T_B3    = 5500,
  parameter int T_B6    = 2000,
  parameter int T_NP    = 2000,
  parameter int T_PR    = 3300,
  parameter int T_NR    = 6100,
  parameter int T_HOLD  = 5000,
  parameter int T_DRAIN = 2000,
  parameter int T_MASK  = 18000
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic posRailUp,
  input  logic ovcPos,
  input  logic ovcNeg,
  output logic refOn,
  output logic boost3On,
  output logic boost6On,
  output logic negPumpOn,
  output logic posRegOn,
  output logic negRegOn,
  output logic forcedClk,
  output logic startDone,
  output logic busy,
  output logic fault
);

  seqStrobe_t        stb;
  logic [NSTAGE-1:0] stageQ;
  logic              cntDone;
  logic              maskDone;

  rail_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .posRailUp(posRailUp),
    .ovcPos(ovcPos), .ovcNeg(ovcNeg), .cntDone(cntDone), .maskDone(maskDone),
    .stb(stb), .busy(busy), .fault(fault)
  );

  rail_seq_path #(
    .T_B3(T_B3), .T_B6(T_B6), .T_NP(T_NP), .T_PR(T_PR), .T_NR(T_NR),
    .T_HOLD(T_HOLD), .T_DRAIN(T_DRAIN), .T_MASK(T_MASK)
  ) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .stageQ(stageQ), .forcedClk(forcedClk),
    .startDone(startDone), .cntDone(cntDone), .maskDone(maskDone)
  );

  assign refOn     = stageQ[STG_REF];
  assign boost3On  = stageQ[STG_B3];
  assign boost6On  = stageQ[STG_B6];
  assign negPumpOn = stageQ[STG_NP];
  assign posRegOn  = stageQ[STG_PR];
  assign negRegOn  = stageQ[STG_NR];

  a_r11_fault_all_off: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (stageQ == '0));
  a_r6_busy_neg_off: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !negRegOn);
  a_r4_done_with_neg: assert property (@(posedge clk) disable iff (!rstN)
    startDone |-> negRegOn);

endmodule

// File: tb/rail_sequencer_bench.sv
module rail_sequencer_bench;

  localparam int T_B3 = 6, T_B6 = 3, T_NP = 3, T_PR = 4;
  localparam int T_NR = 5, T_HOLD = 4, T_DRAIN = 3, T_MASK = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic posRailUp = 1'b0;
  logic ovcPos = 1'b0;
  logic ovcNeg = 1'b0;
  logic refOn, boost3On, boost6On, negPumpOn, posRegOn, negRegOn;
  logic forcedClk, startDone, busy, fault;
  logic [5:0] stv;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  assign stv = {negRegOn, posRegOn, negPumpOn, boost6On, boost3On, refOn};

  rail_sequencer #(
    .T_B3(T_B3), .T_B6(T_B6), .T_NP(T_NP), .T_PR(T_PR), .T_NR(T_NR),
    .T_HOLD(T_HOLD), .T_DRAIN(T_DRAIN), .T_MASK(T_MASK)
  ) u_rail_sequencer (
    .clk(clk), .rstN(rstN), .enable(enable), .posRailUp(posRailUp),
    .ovcPos(ovcPos), .ovcNeg(ovcNeg), .refOn(refOn), .boost3On(boost3On),
    .boost6On(boost6On), .negPumpOn(negPumpOn), .posRegOn(posRegOn),
    .negRegOn(negRegOn), .forcedClk(forcedClk), .startDone(startDone),
    .busy(busy), .fault(fault)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expectRise(input int idx, input int n, input string req);
    step(n - 1);
    chk(req, int'(stv[idx]), 0);
    step(1);
    chk(req, int'(stv[idx]), 1);
  endtask

  // R1 and R9: reset state, then no start until enable seen low
  task automatic tResetArm();
    step(3);
    chk("R1 outputs in reset", int'({stv, forcedClk, startDone, busy, fault}), 0);
    rstN = 1'b1;
    step(10);
    chk("R9 no start while unarmed", int'(stv), 0);
    enable = 1'b0;
    step(1);
    enable = 1'b1;
    step(1);
    chk("R9 start after enable low", int'(refOn), 1);
    enable = 1'b0;
    step(40);
    chk("R9 back to idle", int'(stv), 0);
  endtask

  // R2 R3 R4 R5: full startup
  task automatic tStartup(input bit checkRail);
    posRailUp = 1'b0;
    enable = 1'b1;
    step(1);
    chk("R2 ref on", int'(refOn), 1);
    chk("R3 forced on", int'(forcedClk), 1);
    expectRise(1, T_B3, "R2 boost3");
    expectRise(2, T_B6, "R2 boost6");
    expectRise(3, T_NP, "R2 negPump");
    chk("R3 forced held", int'(forcedClk), 1);
    expectRise(4, T_PR, "R2 posReg");
    chk("R3 forced off", int'(forcedClk), 0);
    chk("R5 order", int'(stv), 6'b011111);
    if (checkRail) begin
      step(3);
      chk("R4 waits for rail", int'(negRegOn), 0);
      posRailUp = 1'b1;
      expectRise(5, T_NR + 1, "R4 negReg");
      chk("R4 done strobe", int'(startDone), 1);
      step(1);
      chk("R4 done single", int'(startDone), 0);
      chk("R5 all on", int'(stv), 6'b111111);
    end
  endtask

  // R6: ordered stop from run
  task automatic tStop();
    enable = 1'b0;
    step(1);
    chk("R6 negReg off", int'(negRegOn), 0);
    chk("R6 busy", int'(busy), 1);
    chk("R6 posReg held", int'(posRegOn), 1);
    step(T_HOLD - 1);
    chk("R6 posReg hold", int'(posRegOn), 1);
    step(1);
    chk("R6 posReg off", int'(posRegOn), 0);
    chk("R6 pumps on", int'(stv), 6'b001111);
    step(T_DRAIN - 1);
    chk("R6 drain busy", int'(busy), 1);
    step(1);
    chk("R6 all off", int'(stv), 0);
    chk("R6 busy off", int'(busy), 0);
    posRailUp = 1'b0;
  endtask

  // R7: stop before posReg skips hold
  task automatic tEarlyStop();
    enable = 1'b1;
    step(1);
    step(T_B3 + T_B6);
    chk("R7 partway", int'(stv), 6'b000111);
    enable = 1'b0;
    step(1);
    chk("R7 busy", int'(busy), 1);
    chk("R7 no more stages", int'(stv), 6'b000111);
    step(T_DRAIN - 1);
    chk("R7 drain busy", int'(busy), 1);
    step(1);
    chk("R7 all off", int'(stv), 0);
    chk("R7 busy off", int'(busy), 0);
  endtask

  // R8: enable high during stop
  task automatic tRestart();
    tStartup(1'b1);
    enable = 1'b0;
    step(1);
    chk("R8 busy", int'(busy), 1);
    enable = 1'b1;
    step(T_HOLD + T_DRAIN - 1);
    chk("R8 stop continues", int'(busy), 1);
    step(1);
    chk("R8 stop finished", int'(stv), 0);
    step(1);
    chk("R8 restart", int'(refOn), 1);
    enable = 1'b0;
    posRailUp = 1'b0;
    step(40);
    chk("R8 idle", int'(stv), 0);
  endtask

  // R10 R11: mask window and fault latch
  task automatic tFault();
    enable = 1'b1;
    step(1);
    chk("R10 ref on", int'(refOn), 1);
    ovcNeg = 1'b1;
    step(T_MASK - 1);
    chk("R10 masked", int'(fault), 0);
    step(1);
    chk("R10 masked at edge", int'(fault), 0);
    chk("R10 stages kept", int'(stv), 6'b011111);
    ovcNeg = 1'b0;
    ovcPos = 1'b1;
    step(1);
    chk("R11 fault set", int'(fault), 1);
    chk("R11 all off", int'(stv), 0);
    ovcPos = 1'b0;
    step(3);
    chk("R11 fault held", int'(fault), 1);
    enable = 1'b0;
    step(3);
    chk("R11 fault held low", int'(fault), 1);
    chk("R11 still off", int'(refOn), 0);
    enable = 1'b1;
    step(1);
    chk("R11 fault cleared", int'(fault), 0);
    chk("R11 restart", int'(refOn), 1);
    enable = 1'b0;
    step(40);
    chk("R11 idle", int'(stv), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    tResetArm();
    tStartup(1'b1);
    tStop();
    tEarlyStop();
    tRestart();
    tFault();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule